// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Multiplier

This block multiplies two 64-bit integers over several clock cycles and returns the low 64 bits of the product. On each iteration cycle it takes the lowest 10-bit digit of the remaining second operand. It multiplies the first operand by that digit and adds the result to an accumulator. It then shifts the first operand left by 10 and the second operand right by 10. Before the first iteration, one cycle is spent finding how many 10-bit digits of the second operand are needed to reach its highest set bit. Iteration then stops once that many digits are consumed, so a small second operand finishes early.

A request is offered with a valid signal and two operands. It is taken on a clock edge where the unit shows ready. Only one multiply is in flight at a time: ready drops the cycle after a request is taken and comes back in the cycle in which done pulses. A caller that keeps its next request pending can therefore have it accepted in the done cycle, with no idle gap. The result register keeps the last product until the next done pulse.

Top module: `early_exit_mul`

## Requirements
- R1: In the done cycle, `result` equals the low 64 bits of `req_a * req_b`, using the operands captured at acceptance.
- R2: With acceptance at clock edge 0, `done` is high in cycle N+2 after that edge. N is 1 when `req_b` is zero; otherwise N is floor(m/10)+1, where m is the bit index (0 = LSB) of the most significant set bit of `req_b`.
- R3: `req_ready` is low from the cycle after acceptance until the done cycle. Operands and valid offered during that time are ignored and do not change the result or the latency.
- R4: A zero `req_b` gives a result of zero with `done` in cycle 3 after acceptance.
- R5: Outside the done cycle, `result` keeps its value and `done` stays low while the unit is idle.
- R6: While `rst` is high and in the cycle after it, `req_ready` is 1 and `done` is 0. Reset also abandons a multiply in progress, and `result` is cleared to zero.
- R7: `done` lasts one cycle, and `req_ready` is high in that cycle. A request accepted there completes N+2 cycles later, like any other request.
- R8: Occupancy from acceptance to done is never below 3 or above 9 cycles. A second operand with bit 63 set takes exactly 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request on this edge |
| req_a | input | 64 | Multiplicand |
| req_b | input | 64 | Multiplier; its highest set bit sets the latency |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 64 | Low 64 bits of the product, held until the next done |

## Verification
The bench drives inputs on falling edges and counts falling edges from the edge that accepts a request. It expects `done` exactly N+2 counts later, where N is computed from the highest set bit of the second operand. Every intermediate count must show `req_ready` low and no `done`, so early, late or duplicated completions are caught. Result and ready are sampled in that same done cycle. Idle gaps after a result are checked for a held value, and a back-to-back request issued in the done cycle is timed from the same count.

// File: rtl/emx_pkg.sv
package emx_pkg;
  localparam int EMX_WIDTH_DEF = 64;
  localparam int EMX_DIGIT_DEF = 10;

  typedef enum logic [1:0] {
    EMX_IDLE = 2'd0,
    EMX_CAP  = 2'd1,
    EMX_ITER = 2'd2,
    EMX_FIN  = 2'd3
  } emx_state_e;
endpackage

// File: rtl/emx_span_calc.sv
// Number of digit steps needed to cover the highest set bit of an operand.
module emx_span_calc #(
  parameter int W  = 64,
  parameter int D  = 10,
  parameter int CW = 3
) (
  input  logic [W-1:0]  opnd,
  output logic [CW-1:0] steps
);
  localparam int NDIG = (W + D - 1) / D;
  localparam int EXT  = NDIG * D;

  logic [EXT-1:0]  ext;
  logic [NDIG-1:0] nz;

  always_comb begin
    ext = '0;
    ext[W-1:0] = opnd;
  end

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_dig
      assign nz[g] = |ext[g*D +: D];
    end
  endgenerate

  always_comb begin
    steps = CW'(1);
    for (int k = 0; k < NDIG; k++) begin
      if (nz[k]) steps = CW'(k + 1);
    end
  end
endmodule

// File: rtl/emx_partial_mac.sv
// Accumulate one digit's partial product into the running sum.
module emx_partial_mac #(
  parameter int W = 64,
  parameter int D = 10
) (
  input  logic [W-1:0] mcand,
  input  logic [D-1:0] digit,
  input  logic [W-1:0] acc,
  output logic [W-1:0] sum
);
  logic [W+D-1:0] prod;

  assign prod = {{D{1'b0}}, mcand} * {{W{1'b0}}, digit};
  assign sum  = acc + prod[W-1:0];
endmodule

// File: rtl/early_exit_mul.sv
module early_exit_mul
  import emx_pkg::*;
#(
  parameter int W = EMX_WIDTH_DEF,
  parameter int D = EMX_DIGIT_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int NDIG = (W + D - 1) / D;
  localparam int CW   = $clog2(NDIG + 1);

  emx_state_e    st;
  logic [W-1:0]  a_q, b_q, acc_q, res_q;
  logic [CW-1:0] cnt_q;
  logic          ready_q, done_q;

  logic [CW-1:0] span;
  logic [W-1:0]  mac_sum;
  logic          take;

  assign take = req_valid && ready_q;

  emx_span_calc #(.W(W), .D(D), .CW(CW)) u_span (
    .opnd  (b_q),
    .steps (span)
  );

  emx_partial_mac #(.W(W), .D(D)) u_mac (
    .mcand (a_q),
    .digit (b_q[D-1:0]),
    .acc   (acc_q),
    .sum   (mac_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= EMX_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      res_q   <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        EMX_IDLE, EMX_FIN: begin
          if (take) begin
            a_q     <= req_a;
            b_q     <= req_b;
            acc_q   <= '0;
            ready_q <= 1'b0;
            st      <= EMX_CAP;
          end else begin
            ready_q <= 1'b1;
            st      <= EMX_IDLE;
          end
        end
        EMX_CAP: begin
          cnt_q <= span;
          st    <= EMX_ITER;
        end
        EMX_ITER: begin
          acc_q <= mac_sum;
          a_q   <= a_q << D;
          b_q   <= b_q >> D;
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            res_q   <= mac_sum;
            done_q  <= 1'b1;
            ready_q <= 1'b1;
            st      <= EMX_FIN;
          end
        end
        default: st <= EMX_IDLE;
      endcase
    end
  end

  assign req_ready = ready_q;
  assign done      = done_q;
  assign result    = res_q;
endmodule

// File: rtl/emx_checker.sv
module emx_checker #(
  parameter int W = 64,
  parameter int D = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic         req_ready,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int NDIG = (W + D - 1) / D;

  logic [7:0] occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else if (req_valid && req_ready) occ <= 8'd1;
    else if (done) occ <= '0;
    else if (occ != 8'd0) occ <= occ + 8'd1;
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R3

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (req_ready && !done)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R5

  AST_OCC_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    done |-> (occ >= 8'd3 && occ <= 8'(NDIG + 2))); // R8
endmodule

bind early_exit_mul emx_checker #(.W(W), .D(D)) u_emx_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .result    (result)
);

// File: tb/test_early_exit_mul.sv
`timescale 1ns/1ps
module test_early_exit_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_a = '0;
  logic [63:0] req_b = '0;
  logic        done;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  early_exit_mul #(.W(64), .D(10)) i_early_exit_mul (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_a(req_a), .req_b(req_b), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_iters(input logic [63:0] b);
    int n = 1;
    for (int i = 0; i < 64; i++) if (b[i]) n = i / 10 + 1;
    return n;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Called at a falling edge; returns at the falling edge of the done cycle.
  task automatic run(input logic [63:0] a, input logic [63:0] b, input bit junk);
    int n = exp_iters(b);
    int lat;
    int guard = 0;
    logic [63:0] prod = a * b;
    req_a = a; req_b = b; req_valid = 1'b1;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      chk(!req_ready, "R3 ready low while busy", 64'(req_ready), 64'd0);
      if (junk && lat <= n) begin
        req_valid = 1'b1; req_a = ~a; req_b = '1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(done && lat == n + 2, "R2 latency", 64'(lat), 64'(n + 2));
    chk(result == prod, junk ? "R3 ignored busy request, R1 product" : "R1 product", result, prod);
    chk(req_ready, "R7 ready in done cycle", 64'(req_ready), 64'd1);
    if (b == 64'd0) chk(lat == 3 && result == 64'd0, "R4 zero operand", 64'(lat), 64'd3);
    if (b[63]) chk(lat == 9, "R8 worst-case occupancy", 64'(lat), 64'd9);
  endtask

  task automatic idle(input int k);
    logic [63:0] held = result;
    repeat (k) begin
      @(negedge clk);
      chk(!done && result == held, "R5 result held while idle", result, held);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] bvals [6];
    bvals[0] = 64'd0;
    bvals[1] = 64'd1;
    bvals[2] = 64'd512;
    bvals[3] = 64'd1024;
    bvals[4] = 64'h8000_0000_0000_0000;
    bvals[5] = '1;

    repeat (3) @(negedge clk);
    chk(req_ready && !done && result == 64'd0, "R6 reset state", {62'd0, req_ready, done}, 64'd2);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done, "R6 ready after reset", {62'd0, req_ready, done}, 64'd2);

    foreach (bvals[i]) begin
      run(64'h0123_4567_89AB_CDEF, bvals[i], 1'b0); idle(2);
      run('1, bvals[i], 1'b0); idle(1);
      run(64'd0, bvals[i], 1'b0); idle(1);
    end

    for (int i = 0; i < 64; i++) begin
      run(rnd64(), 64'd1 << i, 1'b0);
      run(rnd64(), (64'd1 << i) | (rnd64() >> (64 - i)), 1'b0);
      idle(1);
    end

    // back-to-back: each new request is issued in the done cycle (R7)
    run(rnd64(), 64'd5, 1'b0);
    run(rnd64(), '1, 1'b0);
    run(rnd64(), 64'd0, 1'b0);
    idle(2);

    // busy-time requests are ignored (R3)
    for (int i = 0; i < 20; i++) begin
      run(rnd64(), rnd64() >> (i * 3), 1'b1);
      idle(1);
    end

    for (int i = 0; i < 300; i++) begin
      run(rnd64(), rnd64() >> ($urandom() % 64), i[0]);
      if (i % 3 == 0) idle(1);
    end

    // reset in the middle of a multiply (R6)
    req_a = rnd64(); req_b = '1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready && !done && result == 64'd0, "R6 reset mid-operation", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !done, "R6 idle after reset", {62'd0, req_ready, done}, 64'd2);
    idle(12);
    run(64'd7, 64'd6, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule